// File: doc/BRIEF.md
# Per-Bank Precharge and Activate Timing Guard

This block keeps the timing state of a single SDRAM bank for a memory controller's command scheduler. The scheduler reports each command it issues to the bank as a one-cycle pulse: row activate, column read, column read with auto-precharge, or precharge. The block holds a set of down-counters loaded from programmable cycle counts. From them it derives two permission flags that tell the scheduler whether a precharge or an activate may be issued in the current cycle.

A precharge after a read is timed from the internal read point, which is the external read plus the additive latency. It must also respect the minimum row active time. An activate needs the precharge time and the row cycle time to be met together. A read with auto-precharge starts the bank's precharge internally, in the first cycle in which an explicit precharge would have been legal. Any command that arrives while it is not permitted raises a sticky violation flag and is otherwise discarded.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset the bank is closed, `actAllowed` is 1, `preAllowed` is 0 and `violation` is 0.
- R2: A permitted activate in cycle t opens the bank: `bankOpen` is 1 and `actAllowed` is 0 from cycle t+1 onward.
- R3: With no reads, a bank activated in cycle t first shows `preAllowed` = 1 in cycle t+`cfgActToPre`.
- R4: A read in cycle r keeps `preAllowed` low until cycle r+`cfgAddLat`+`cfgRdToPre`. The first permitted cycle is the later of this limit and the R3 limit.
- R5: After a precharge in cycle p of a bank activated in cycle a, `actAllowed` first becomes 1 in cycle max(p+`cfgPreTime`, a+`cfgRowCycle`).
- R6: A read with auto-precharge issued in cycle r starts an internal precharge in cycle i = max(r+`cfgAddLat`+`cfgRdToPre`, a+`cfgActToPre`). `bankOpen` is 1 in cycle i and 0 from i+1. `preAllowed` stays 0 the whole time. `actAllowed` first becomes 1 in cycle max(i+`cfgPreTime`, a+`cfgRowCycle`).
- R7: `violation` becomes 1 in the cycle after any illegal command, and stays 1 until reset. Illegal commands are: an activate while `actAllowed` is 0, a precharge while `preAllowed` is 0, a read of either kind while the bank is closed or an auto-precharge is pending, and more than one command pulse in the same cycle.
- R8: An illegal command changes neither the bank's open state nor any timing count.
- R9: A timing parameter of 0 or 1 permits the dependent command in the cycle right after the command that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| actIssue | input | 1 | Activate issued this cycle |
| rdIssue | input | 1 | Read issued this cycle |
| rdApIssue | input | 1 | Read with auto-precharge issued this cycle |
| preIssue | input | 1 | Precharge issued this cycle |
| cfgAddLat | input | CNT_W | Additive latency in cycles |
| cfgRdToPre | input | CNT_W | Internal read to precharge delay in cycles |
| cfgActToPre | input | CNT_W | Minimum activate to precharge time in cycles |
| cfgPreTime | input | CNT_W | Precharge duration in cycles |
| cfgRowCycle | input | CNT_W | Minimum activate to activate time in cycles |
| preAllowed | output | 1 | A precharge may be issued this cycle |
| actAllowed | output | 1 | An activate may be issued this cycle |
| bankOpen | output | 1 | A row is open in the bank |
| violation | output | 1 | Sticky illegal-command flag |

## Verification
A counter that loads the wrong value, or that misses a decrement, shows up as the wrong first cycle of `preAllowed` or `actAllowed`. The bench therefore checks both the cycle just before each limit and the limit cycle itself. A mistimed auto-precharge shows up one cycle early or late on the fall of `bankOpen`, and again later on the first cycle of `actAllowed`. An illegal command that leaks into the state shows up through `bankOpen` or a shifted permission edge. It is also visible one cycle later on `violation`.

// File: rtl/bank_timing_pkg.sv
`timescale 1ns/1ps
package bank_timing_pkg;
  // Load strobes sent by the control to the timing counters
  typedef struct packed {
    logic loadRas;   // activate-to-precharge window
    logic loadRc;    // activate-to-activate window
    logic loadRtp;   // read-to-precharge window (includes additive latency)
    logic loadRp;    // precharge duration window
  } timerLoad_t;
endpackage

// File: rtl/timing_down_counter.sv
`timescale 1ns/1ps
module timing_down_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         isZero
);
  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= loadVal;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign isZero = (count == '0);

  // R5: an unloaded, non-zero counter drops by exactly one each cycle
  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/bank_timing_counters.sv
`timescale 1ns/1ps
module bank_timing_counters
  import bank_timing_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  timerLoad_t       strobes,
  input  logic [CNT_W-1:0] cfgAddLat,
  input  logic [CNT_W-1:0] cfgRdToPre,
  input  logic [CNT_W-1:0] cfgActToPre,
  input  logic [CNT_W-1:0] cfgPreTime,
  input  logic [CNT_W-1:0] cfgRowCycle,
  output logic             rasDone,
  output logic             rcDone,
  output logic             rtpDone,
  output logic             rpDone
);
  localparam int SUM_W     = CNT_W + 1;
  localparam int NUM_PLAIN = 3;

  // A window of N cycles loads N-1: the command's own cycle counts as one
  function automatic logic [CNT_W-1:0] satDec(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [NUM_PLAIN-1:0]            plainLoad;
  logic [NUM_PLAIN-1:0][CNT_W-1:0] plainVal;
  logic [NUM_PLAIN-1:0]            plainDone;

  assign plainLoad = {strobes.loadRp, strobes.loadRc, strobes.loadRas};
  assign plainVal  = {satDec(cfgPreTime), satDec(cfgRowCycle), satDec(cfgActToPre)};

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    timing_down_counter #(.W(CNT_W)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (plainLoad[i]),
      .loadVal (plainVal[i]),
      .isZero  (plainDone[i])
    );
  end

  assign rasDone = plainDone[0];
  assign rcDone  = plainDone[1];
  assign rpDone  = plainDone[2];

  // Read window spans additive latency plus internal read-to-precharge delay
  logic [SUM_W-1:0] rtpSum;
  logic [SUM_W-1:0] rtpVal;
  assign rtpSum = SUM_W'(cfgAddLat) + SUM_W'(cfgRdToPre);
  assign rtpVal = (rtpSum == '0) ? '0 : rtpSum - 1'b1;

  timing_down_counter #(.W(SUM_W)) i_rtpCnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (strobes.loadRtp),
    .loadVal (rtpVal),
    .isZero  (rtpDone)
  );

  // R5: a precharge window longer than one cycle blocks the next cycle
  assert_rp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.loadRp && cfgPreTime > 1) |=> !rpDone);

  // R4: a read window longer than one cycle blocks the next cycle
  assert_rtp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.loadRtp && rtpSum > 1) |=> !rtpDone);
endmodule

// File: rtl/bank_timing_ctrl.sv
`timescale 1ns/1ps
module bank_timing_ctrl
  import bank_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       actIssue,
  input  logic       rdIssue,
  input  logic       rdApIssue,
  input  logic       preIssue,
  input  logic       rasDone,
  input  logic       rcDone,
  input  logic       rtpDone,
  input  logic       rpDone,
  output timerLoad_t strobes,
  output logic       preAllowed,
  output logic       actAllowed,
  output logic       bankOpen,
  output logic       violation
);
  logic       openReg;
  logic       apPending;
  logic       violReg;
  logic [3:0] cmdVec;
  logic       multiCmd;
  logic       anyRead;
  logic       readAllowed;
  logic       internalPre;
  logic       legalAct;
  logic       legalPre;
  logic       legalRd;
  logic       illegal;

  assign cmdVec   = {actIssue, rdIssue, rdApIssue, preIssue};
  assign multiCmd = ($countones(cmdVec) > 1);
  assign anyRead  = rdIssue || rdApIssue;

  // Permission decode
  assign readAllowed = openReg && !apPending;
  assign actAllowed  = !openReg && rpDone && rcDone;
  assign preAllowed  = openReg && !apPending && rasDone && rtpDone;
  // Auto-precharge fires where an explicit precharge would first be legal
  assign internalPre = apPending && rasDone && rtpDone;

  assign legalAct = actIssue && actAllowed  && !multiCmd;
  assign legalPre = preIssue && preAllowed  && !multiCmd;
  assign legalRd  = anyRead  && readAllowed && !multiCmd;
  assign illegal  = (actIssue && !actAllowed) || (preIssue && !preAllowed) ||
                    (anyRead && !readAllowed) || multiCmd;

  always_comb begin
    strobes.loadRas = legalAct;
    strobes.loadRc  = legalAct;
    strobes.loadRtp = legalRd;
    strobes.loadRp  = legalPre || internalPre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      openReg   <= 1'b0;
      apPending <= 1'b0;
      violReg   <= 1'b0;
    end else begin
      if (legalAct)                     openReg <= 1'b1;
      else if (legalPre || internalPre) openReg <= 1'b0;
      if (legalRd && rdApIssue)         apPending <= 1'b1;
      else if (internalPre)             apPending <= 1'b0;
      if (illegal)                      violReg <= 1'b1;
    end
  end

  assign bankOpen  = openReg;
  assign violation = violReg;

  assert_sticky_violation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  assert_illegal_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (actIssue && !actAllowed) |=> violation);

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (actIssue && actAllowed && $countones(cmdVec) == 1) |=> (bankOpen && !actAllowed));

  assert_ap_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    internalPre |=> (!bankOpen && !apPending));

  assert_pending_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    apPending |-> bankOpen);

  assert_bad_pre_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (preIssue && !preAllowed && !internalPre) |=> (bankOpen == $past(bankOpen)));
endmodule

// File: rtl/bank_timing_guard.sv
`timescale 1ns/1ps
module bank_timing_guard
  import bank_timing_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             actIssue,
  input  logic             rdIssue,
  input  logic             rdApIssue,
  input  logic             preIssue,
  input  logic [CNT_W-1:0] cfgAddLat,
  input  logic [CNT_W-1:0] cfgRdToPre,
  input  logic [CNT_W-1:0] cfgActToPre,
  input  logic [CNT_W-1:0] cfgPreTime,
  input  logic [CNT_W-1:0] cfgRowCycle,
  output logic             preAllowed,
  output logic             actAllowed,
  output logic             bankOpen,
  output logic             violation
);
  timerLoad_t strobes;
  logic       rasDone;
  logic       rcDone;
  logic       rtpDone;
  logic       rpDone;

  bank_timing_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .actIssue   (actIssue),
    .rdIssue    (rdIssue),
    .rdApIssue  (rdApIssue),
    .preIssue   (preIssue),
    .rasDone    (rasDone),
    .rcDone     (rcDone),
    .rtpDone    (rtpDone),
    .rpDone     (rpDone),
    .strobes    (strobes),
    .preAllowed (preAllowed),
    .actAllowed (actAllowed),
    .bankOpen   (bankOpen),
    .violation  (violation)
  );

  bank_timing_counters #(.CNT_W(CNT_W)) i_counters (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .cfgAddLat   (cfgAddLat),
    .cfgRdToPre  (cfgRdToPre),
    .cfgActToPre (cfgActToPre),
    .cfgPreTime  (cfgPreTime),
    .cfgRowCycle (cfgRowCycle),
    .rasDone     (rasDone),
    .rcDone      (rcDone),
    .rtpDone     (rtpDone),
    .rpDone      (rpDone)
  );
endmodule

// File: tb/test_bank_timing_guard.sv
`timescale 1ns/1ps
module test_bank_timing_guard;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic actIssue = 1'b0, rdIssue = 1'b0, rdApIssue = 1'b0, preIssue = 1'b0;
  logic [CNT_W-1:0] cfgAddLat = '0, cfgRdToPre = '0, cfgActToPre = '0;
  logic [CNT_W-1:0] cfgPreTime = '0, cfgRowCycle = '0;
  logic preAllowed, actAllowed, bankOpen, violation;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bank_timing_guard #(.CNT_W(CNT_W)) i_bank_timing_guard (
    .clk(clk), .rst_n(rst_n),
    .actIssue(actIssue), .rdIssue(rdIssue), .rdApIssue(rdApIssue), .preIssue(preIssue),
    .cfgAddLat(cfgAddLat), .cfgRdToPre(cfgRdToPre), .cfgActToPre(cfgActToPre),
    .cfgPreTime(cfgPreTime), .cfgRowCycle(cfgRowCycle),
    .preAllowed(preAllowed), .actAllowed(actAllowed),
    .bankOpen(bankOpen), .violation(violation)
  );

  localparam logic [3:0] CMD_ACT = 4'b1000;
  localparam logic [3:0] CMD_RD  = 4'b0100;
  localparam logic [3:0] CMD_RDA = 4'b0010;
  localparam logic [3:0] CMD_PRE = 4'b0001;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Called at a falling edge (cycle k); returns at the falling edge of cycle k+1
  task automatic pulse(input logic [3:0] c);
    {actIssue, rdIssue, rdApIssue, preIssue} = c;
    @(negedge clk);
    {actIssue, rdIssue, rdApIssue, preIssue} = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetDut(input int al, input int rtp, input int ras, input int rp, input int rc);
    rst_n = 1'b0;
    cfgAddLat = CNT_W'(al); cfgRdToPre = CNT_W'(rtp); cfgActToPre = CNT_W'(ras);
    cfgPreTime = CNT_W'(rp); cfgRowCycle = CNT_W'(rc);
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic testReset();
    resetDut(0, 6, 10, 11, 20);
    check("R1 bankOpen", int'(bankOpen), 0);
    check("R1 actAllowed", int'(actAllowed), 1);
    check("R1 preAllowed", int'(preAllowed), 0);
    check("R1 violation", int'(violation), 0);
  endtask

  // Activate-to-precharge limit dominates the read limit; precharge time dominates row cycle
  task automatic testRasDominates();
    resetDut(0, 6, 10, 11, 20);
    pulse(CMD_ACT);                       // cycle 0
    check("R2 bankOpen", int'(bankOpen), 1);
    check("R2 actAllowed low", int'(actAllowed), 0);
    pulse(CMD_RD);                        // cycle 1, read limit at 7
    idle(7);                              // cycle 9
    check("R3 pre before limit", int'(preAllowed), 0);
    idle(1);                              // cycle 10
    check("R3 pre at limit", int'(preAllowed), 1);
    pulse(CMD_PRE);                       // cycle 10
    check("R5 closed after pre", int'(bankOpen), 0);
    idle(9);                              // cycle 20
    check("R5 act before tRP", int'(actAllowed), 0);
    idle(1);                              // cycle 21
    check("R5 act at tRP", int'(actAllowed), 1);
    check("R7 legal sequence clean", int'(violation), 0);
  endtask

  task automatic testRcDominates();
    resetDut(0, 6, 4, 3, 20);
    pulse(CMD_ACT);                       // cycle 0
    idle(2);                              // cycle 3
    check("R3 pre before tRAS", int'(preAllowed), 0);
    idle(1);                              // cycle 4
    check("R3 pre at tRAS", int'(preAllowed), 1);
    pulse(CMD_PRE);                       // cycle 4
    idle(14);                             // cycle 19
    check("R5 act before tRC", int'(actAllowed), 0);
    idle(1);                              // cycle 20
    check("R5 act at tRC", int'(actAllowed), 1);
  endtask

  // Read limit dominates, with and without additive latency
  task automatic testReadLimit(input int al);
    int first;
    first = 1 + al + 6;
    resetDut(al, 6, 4, 3, 4);
    pulse(CMD_ACT);                       // cycle 0
    pulse(CMD_RD);                        // cycle 1
    idle(first - 3);                      // cycle first-1
    check("R4 pre before read limit", int'(preAllowed), 0);
    idle(1);                              // cycle first
    check("R4 pre at read limit", int'(preAllowed), 1);
    pulse(CMD_PRE);
    check("R4 pre accepted", int'(violation), 0);
  endtask

  task automatic testAutoPrecharge(input int ras);
    int ip;
    ip = (ras > 7) ? ras : 7;
    resetDut(0, 6, ras, 11, 4);
    pulse(CMD_ACT);                       // cycle 0
    pulse(CMD_RDA);                       // cycle 1
    idle(ip - 2);                         // cycle ip
    check("R6 open at internal pre", int'(bankOpen), 1);
    check("R6 no explicit pre", int'(preAllowed), 0);
    idle(1);                              // cycle ip+1
    check("R6 closed after internal pre", int'(bankOpen), 0);
    idle(9);                              // cycle ip+10
    check("R6 act before tRP", int'(actAllowed), 0);
    idle(1);                              // cycle ip+11
    check("R6 act at tRP", int'(actAllowed), 1);
    check("R6 no violation", int'(violation), 0);
  endtask

  task automatic testShortTimings(input int v);
    resetDut(0, v, v, v, v);
    pulse(CMD_ACT);                       // cycle 0
    check("R9 pre next cycle", int'(preAllowed), 1);
    pulse(CMD_RD);                        // cycle 1
    check("R9 pre after read", int'(preAllowed), 1);
    pulse(CMD_PRE);                       // cycle 2
    check("R9 act next cycle", int'(actAllowed), 1);
    check("R9 no violation", int'(violation), 0);
  endtask

  task automatic testViolations();
    // early precharge: flagged, ignored, activate window undisturbed
    resetDut(0, 6, 10, 11, 20);
    pulse(CMD_ACT);                       // cycle 0
    pulse(CMD_PRE);                       // cycle 1, illegal
    check("R7 early pre flagged", int'(violation), 1);
    check("R8 bank stays open", int'(bankOpen), 1);
    idle(7);                              // cycle 9
    check("R8 pre still blocked", int'(preAllowed), 0);
    idle(1);                              // cycle 10
    check("R8 pre at original limit", int'(preAllowed), 1);
    check("R7 violation sticky", int'(violation), 1);
    // read to a closed bank
    resetDut(0, 6, 10, 11, 20);
    pulse(CMD_RD);
    check("R7 read closed flagged", int'(violation), 1);
    check("R8 read closed no open", int'(bankOpen), 0);
    // precharge to a closed bank
    resetDut(0, 6, 10, 11, 20);
    pulse(CMD_PRE);
    check("R7 pre closed flagged", int'(violation), 1);
    // two commands in one cycle
    resetDut(0, 6, 10, 11, 20);
    pulse(CMD_ACT | CMD_RD);
    check("R7 double command flagged", int'(violation), 1);
    check("R8 double command ignored", int'(bankOpen), 0);
    check("R8 act still allowed", int'(actAllowed), 1);
    // activate to an open bank
    resetDut(0, 6, 10, 11, 20);
    pulse(CMD_ACT);
    pulse(CMD_ACT);
    check("R7 act open flagged", int'(violation), 1);
    check("R8 bank still open", int'(bankOpen), 1);
  endtask

  initial begin
    testReset();
    testRasDominates();
    testRcDominates();
    testReadLimit(0);
    testReadLimit(9);
    testAutoPrecharge(4);
    testAutoPrecharge(12);
    testShortTimings(0);
    testShortTimings(1);
    testViolations();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule